// File: doc/BRIEF.md
# Per-Cycle Instruction Retirement Controller

This block walks the oldest entries of a reorder buffer once per clock and decides which of them leave the buffer this cycle. It looks at up to `W` head slots, oldest first. For each slot it receives a small set of attributes: ready, squashed, executed, needs-serialising (non-speculative, store-conditional or barrier), load, fault, store, and a sequence number. It also receives one flag that says stores are still waiting to write back.

From these it produces registered results one clock later:

- a retire strobe per slot and a count of instructions actually committed;
- a completion mark per slot;
- the sequence number of the youngest instruction committed so far;
- one-shot requests that send a sequence number back for non-speculative execution or for an uncached load;
- a trap request;
- a stall flag that says a blocking head cut the cycle short.

The block also keeps the architectural program counter as a triple: current, next, and the one after that. The triple steps once per committed instruction.

A raised trap stays pending and blocks all retirement until the trap handler answers with an acknowledge pulse. Trap execution itself, the rename map and the choice of thread are handled elsewhere.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are visited oldest first (slot 0 first). The walk ends at the first slot whose ready bit is low, and no later slot is retired. `commit_count` never exceeds `W`.
- R2: A ready, squashed head is retired (its `retire_strobe` bit is set). It does not add to `commit_count`, does not change `done_seq`, and does not end the walk.
- R3: A ready, unexecuted head with the serialise flag ends the walk. If nothing was committed earlier in the same cycle and `stores_pending` is low, it raises `nonspec_req` with its sequence number on `nonspec_seq`. Otherwise it only waits. The serialise flag takes priority over the load flag.
- R4: A ready, unexecuted head with the load flag and no serialise flag ends the walk and raises `uncached_req` with its sequence number on `uncached_seq`, whether or not stores are pending.
- R5: A ready, executed head with the fault flag ends the walk without retiring. If nothing was committed earlier in the same cycle and `stores_pending` is low, it raises `trap_req`. Otherwise it waits.
- R6: While `trap_req` is high, no slot is retired and no request is made. `trap_req` drops in the cycle after the cycle in which `trap_ack` is sampled high. `trap_ack` has no effect while no trap is pending.
- R7: Each committed instruction moves the triple one step: `pc` takes `next_pc`, `next_pc` takes `next_npc`, and `next_npc` grows by 4. The triple does not move in a cycle with no commit.
- R8: `done_valid` is high exactly when `commit_count` is non-zero. `done_seq` then shows the sequence number of the youngest instruction committed that cycle, and otherwise holds its last value.
- R9: Every committed slot that is not a store has its `completed` bit set. Stores, squashed slots and slots that are not retired have it clear.
- R10: `stall` is high when the walk was ended by a ready, unsquashed head that was not retired. This covers serialise, load, fault and unexecuted heads of no known kind.
- R11: After reset all strobes, counts, requests and `stall` are 0, `done_seq` is 0, and the triple is `RESET_PC`, `RESET_PC`+4, `RESET_PC`+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_ready | input | W | Slot holds an entry that may be examined |
| head_squashed | input | W | Entry was squashed |
| head_executed | input | W | Entry has finished execution |
| head_serial | input | W | Non-speculative, store-conditional or barrier entry |
| head_load | input | W | Entry is a load |
| head_fault | input | W | Entry carries a fault |
| head_store | input | W | Entry is a store |
| head_seq | input | W*SEQ_W | Sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| stores_pending | input | 1 | Stores still waiting to write back |
| trap_ack | input | 1 | Trap handler has taken the pending trap |
| retire_strobe | output | W | Per-slot removal from the buffer |
| completed | output | W | Per-slot completion mark |
| commit_count | output | CNT_W | Instructions committed this cycle |
| done_valid | output | 1 | At least one commit this cycle |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| nonspec_req | output | 1 | Non-speculative execution request |
| nonspec_seq | output | SEQ_W | Sequence number for that request |
| uncached_req | output | 1 | Uncached load request |
| uncached_seq | output | SEQ_W | Sequence number for that load |
| trap_req | output | 1 | Trap pending |
| stall | output | 1 | Cycle cut short by a blocking head |
| pc | output | ADDR_W | Current program counter |
| next_pc | output | ADDR_W | Following program counter |
| next_npc | output | ADDR_W | Program counter after that |

## Verification
The bench targets several corner cases, each paired with the failure it would reveal:

- A serialising or faulting head sitting behind a commit in the same cycle. A design that tests the slot index instead of the commit count, or that ignores pending stores, would fire the request early.
- Squashed slots in front of a blocking head. These show whether squashes are wrongly counted as commits, which would also move the program counter.
- A serialising head that is also a load, and an unexecuted load with stores pending. These expose a swapped priority or a needless wait.
- The trap path, driven through raise, hold, an early acknowledge and a stray acknowledge. A design that keeps retiring while a trap is pending, or that latches a stray acknowledge, shows up in the strobes and in `trap_req`.

// File: rtl/retire_pkg.sv
package retire_pkg;

    // Classification of one head slot, decided independently of its neighbours.
    typedef enum logic [2:0] {
        K_EMPTY    = 3'd0,   // not ready: walk ends here
        K_SQUASHED = 3'd1,   // removed for free
        K_COMMIT   = 3'd2,   // executed, no fault
        K_FAULT    = 3'd3,   // executed, carries a fault
        K_SERIAL   = 3'd4,   // unexecuted, must run non-speculatively
        K_LOAD     = 3'd5,   // unexecuted load, replay uncached
        K_UNKNOWN  = 3'd6    // unexecuted, no known reason
    } slot_kind_e;

endpackage

// File: rtl/retire_slot_class.sv
module retire_slot_class
    import retire_pkg::*;
(
    input  logic       ready_i,
    input  logic       squashed_i,
    input  logic       executed_i,
    input  logic       serial_i,
    input  logic       load_i,
    input  logic       fault_i,
    output slot_kind_e kind_o
);

    always_comb begin
        if (!ready_i)          kind_o = K_EMPTY;
        else if (squashed_i)   kind_o = K_SQUASHED;
        else if (!executed_i) begin
            if (serial_i)      kind_o = K_SERIAL;
            else if (load_i)   kind_o = K_LOAD;
            else               kind_o = K_UNKNOWN;
        end
        else if (fault_i)      kind_o = K_FAULT;
        else                   kind_o = K_COMMIT;
    end

endmodule

// File: rtl/retire_scan.sv
module retire_scan
    import retire_pkg::*;
#(
    parameter int W     = 4,
    parameter int SEQ_W = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic               enable_i,
    input  slot_kind_e         kind_i [W],
    input  logic [W-1:0]       store_i,
    input  logic [W*SEQ_W-1:0] seq_i,
    input  logic               stores_pending_i,
    output logic [W-1:0]       retire_o,
    output logic [W-1:0]       completed_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               done_valid_o,
    output logic [SEQ_W-1:0]   done_seq_o,
    output logic               serial_req_o,
    output logic [SEQ_W-1:0]   serial_seq_o,
    output logic               uncached_req_o,
    output logic [SEQ_W-1:0]   uncached_seq_o,
    output logic               trap_o,
    output logic               stall_o
);

    always_comb begin
        logic stop;
        logic first_free;
        stop           = !enable_i;
        retire_o       = '0;
        completed_o    = '0;
        count_o        = '0;
        done_valid_o   = 1'b0;
        done_seq_o     = '0;
        serial_req_o   = 1'b0;
        serial_seq_o   = '0;
        uncached_req_o = 1'b0;
        uncached_seq_o = '0;
        trap_o         = 1'b0;
        stall_o        = 1'b0;
        for (int i = 0; i < W; i++) begin
            first_free = (count_o == '0) && !stores_pending_i;
            if (!stop) begin
                case (kind_i[i])
                    K_EMPTY: stop = 1'b1;
                    K_SQUASHED: retire_o[i] = 1'b1;
                    K_COMMIT: begin
                        retire_o[i]    = 1'b1;
                        completed_o[i] = !store_i[i];
                        count_o        = count_o + CNT_W'(1);
                        done_valid_o   = 1'b1;
                        done_seq_o     = seq_i[i*SEQ_W +: SEQ_W];
                    end
                    K_SERIAL: begin
                        stop    = 1'b1;
                        stall_o = 1'b1;
                        if (first_free) begin
                            serial_req_o = 1'b1;
                            serial_seq_o = seq_i[i*SEQ_W +: SEQ_W];
                        end
                    end
                    K_LOAD: begin
                        stop           = 1'b1;
                        stall_o        = 1'b1;
                        uncached_req_o = 1'b1;
                        uncached_seq_o = seq_i[i*SEQ_W +: SEQ_W];
                    end
                    K_FAULT: begin
                        stop    = 1'b1;
                        stall_o = 1'b1;
                        trap_o  = first_free;
                    end
                    default: begin
                        stop    = 1'b1;
                        stall_o = 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/retire_pc_step.sv
module retire_pc_step #(
    parameter int W          = 4,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = $clog2(W + 1),
    parameter int INSN_BYTES = 4
) (
    input  logic [CNT_W-1:0]  steps_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] npc_i,
    input  logic [ADDR_W-1:0] nnpc_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o,
    output logic [ADDR_W-1:0] nnpc_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    always_comb begin
        pc_o   = pc_i;
        npc_o  = npc_i;
        nnpc_o = nnpc_i;
        for (int k = 0; k < W; k++) begin
            if (k < int'(steps_i)) begin
                pc_o   = npc_o;
                npc_o  = nnpc_o;
                nnpc_o = nnpc_o + STEP;
            end
        end
    end

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
    import retire_pkg::*;
#(
    parameter int          W          = 4,
    parameter int          SEQ_W      = 16,
    parameter int          ADDR_W     = 32,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000,
    localparam int         CNT_W      = $clog2(W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       head_ready,
    input  logic [W-1:0]       head_squashed,
    input  logic [W-1:0]       head_executed,
    input  logic [W-1:0]       head_serial,
    input  logic [W-1:0]       head_load,
    input  logic [W-1:0]       head_fault,
    input  logic [W-1:0]       head_store,
    input  logic [W*SEQ_W-1:0] head_seq,
    input  logic               stores_pending,
    input  logic               trap_ack,
    output logic [W-1:0]       retire_strobe,
    output logic [W-1:0]       completed,
    output logic [CNT_W-1:0]   commit_count,
    output logic               done_valid,
    output logic [SEQ_W-1:0]   done_seq,
    output logic               nonspec_req,
    output logic [SEQ_W-1:0]   nonspec_seq,
    output logic               uncached_req,
    output logic [SEQ_W-1:0]   uncached_seq,
    output logic               trap_req,
    output logic               stall,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [ADDR_W-1:0]  next_npc
);

    localparam logic [ADDR_W-1:0] PC0  = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    typedef struct packed {
        logic [W-1:0]      retire;
        logic [W-1:0]      completed;
        logic [CNT_W-1:0]  count;
        logic              done_valid;
        logic [SEQ_W-1:0]  done_seq;
        logic              serial_req;
        logic [SEQ_W-1:0]  serial_seq;
        logic              uncached_req;
        logic [SEQ_W-1:0]  uncached_seq;
        logic              trap;
        logic              stall;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] nnpc;
    } state_t;

    state_t st_d, st_q;

    slot_kind_e        kind [W];
    logic [W-1:0]      sc_retire, sc_completed;
    logic [CNT_W-1:0]  sc_count;
    logic              sc_done_valid, sc_serial_req, sc_uncached_req, sc_trap, sc_stall;
    logic [SEQ_W-1:0]  sc_done_seq, sc_serial_seq, sc_uncached_seq;
    logic [ADDR_W-1:0] pc_n, npc_n, nnpc_n;

    for (genvar g = 0; g < W; g++) begin : g_slot
        retire_slot_class u_class (
            .ready_i    (head_ready[g]),
            .squashed_i (head_squashed[g]),
            .executed_i (head_executed[g]),
            .serial_i   (head_serial[g]),
            .load_i     (head_load[g]),
            .fault_i    (head_fault[g]),
            .kind_o     (kind[g])
        );
    end

    retire_scan #(.W(W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_scan (
        .enable_i         (!st_q.trap),
        .kind_i           (kind),
        .store_i          (head_store),
        .seq_i            (head_seq),
        .stores_pending_i (stores_pending),
        .retire_o         (sc_retire),
        .completed_o      (sc_completed),
        .count_o          (sc_count),
        .done_valid_o     (sc_done_valid),
        .done_seq_o       (sc_done_seq),
        .serial_req_o     (sc_serial_req),
        .serial_seq_o     (sc_serial_seq),
        .uncached_req_o   (sc_uncached_req),
        .uncached_seq_o   (sc_uncached_seq),
        .trap_o           (sc_trap),
        .stall_o          (sc_stall)
    );

    retire_pc_step #(.W(W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .INSN_BYTES(INSN_BYTES)) u_pc (
        .steps_i (sc_count),
        .pc_i    (st_q.pc),
        .npc_i   (st_q.npc),
        .nnpc_i  (st_q.nnpc),
        .pc_o    (pc_n),
        .npc_o   (npc_n),
        .nnpc_o  (nnpc_n)
    );

    always_comb begin
        st_d              = st_q;
        st_d.retire       = sc_retire;
        st_d.completed    = sc_completed;
        st_d.count        = sc_count;
        st_d.done_valid   = sc_done_valid;
        if (sc_done_valid) st_d.done_seq = sc_done_seq;
        st_d.serial_req   = sc_serial_req;
        st_d.serial_seq   = sc_serial_seq;
        st_d.uncached_req = sc_uncached_req;
        st_d.uncached_seq = sc_uncached_seq;
        st_d.trap         = st_q.trap ? !trap_ack : sc_trap;
        st_d.stall        = sc_stall;
        st_d.pc           = pc_n;
        st_d.npc          = npc_n;
        st_d.nnpc         = nnpc_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pc   <= PC0;
            st_q.npc  <= PC0 + STEP;
            st_q.nnpc <= PC0 + STEP + STEP;
        end else begin
            st_q <= st_d;
        end
    end

    assign retire_strobe = st_q.retire;
    assign completed     = st_q.completed;
    assign commit_count  = st_q.count;
    assign done_valid    = st_q.done_valid;
    assign done_seq      = st_q.done_seq;
    assign nonspec_req   = st_q.serial_req;
    assign nonspec_seq   = st_q.serial_seq;
    assign uncached_req  = st_q.uncached_req;
    assign uncached_seq  = st_q.uncached_seq;
    assign trap_req      = st_q.trap;
    assign stall         = st_q.stall;
    assign pc            = st_q.pc;
    assign next_pc       = st_q.npc;
    assign next_npc      = st_q.nnpc;

endmodule

// File: rtl/retire_ctrl_checker.sv
module retire_ctrl_checker #(
    parameter int W          = 4,
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4,
    parameter int CNT_W      = $clog2(W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      retire_strobe,
    input logic [W-1:0]      completed,
    input logic [CNT_W-1:0]  commit_count,
    input logic              done_valid,
    input logic              nonspec_req,
    input logic              uncached_req,
    input logic              trap_req,
    input logic              stall,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic [ADDR_W-1:0] next_npc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    // R1: never more commits than slots
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(commit_count) <= W);

    // R1: commits cannot exceed the number of retired slots
    p_count_le_retire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(commit_count) <= $countones(retire_strobe));

    // R3: a non-speculative request only in a cycle with no commit
    p_serial_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nonspec_req |-> commit_count == '0);

    // R3 R4: at most one backward request per cycle
    p_one_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({nonspec_req, uncached_req}) <= 1);

    // R6: a held trap blocks all retirement
    p_trap_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && $past(trap_req)) |-> (retire_strobe == '0 && !nonspec_req && !uncached_req));

    // R7: the triple stays evenly spaced
    p_pc_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc == pc + STEP && next_npc == next_pc + STEP);

    // R7: no commit, no movement
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_count == '0 |-> pc == $past(pc));

    // R8: done flag tracks the count
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid == (commit_count != '0));

    // R9: completion only on retired slots
    p_completed_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (completed & ~retire_strobe) == '0);

    // R10: a stalled cycle never reaches full width
    p_stall_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> int'(commit_count) < W);

endmodule

bind retire_ctrl retire_ctrl_checker #(
    .W(W), .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .retire_strobe (retire_strobe),
    .completed     (completed),
    .commit_count  (commit_count),
    .done_valid    (done_valid),
    .nonspec_req   (nonspec_req),
    .uncached_req  (uncached_req),
    .trap_req      (trap_req),
    .stall         (stall),
    .pc            (pc),
    .next_pc       (next_pc),
    .next_npc      (next_npc)
);

// File: tb/retire_ctrl_test.sv
module retire_ctrl_test;

    localparam int W     = 4;
    localparam int SEQ_W = 16;
    localparam int AW    = 32;
    localparam int CW    = 3;
    localparam logic [31:0] PC0 = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] rdy, sq, ex, sr, ld, ft, stq;
    logic [W*SEQ_W-1:0] seqv;
    logic sp, ack;
    logic [W-1:0] ret, cmp;
    logic [CW-1:0] cnt;
    logic dv, nsr, ucr, trp, stl;
    logic [SEQ_W-1:0] dseq, nss, ucs;
    logic [AW-1:0] pc, npc, nnpc;

    int total = 0;
    int bad = 0;

    logic        m_trap;
    logic [31:0] m_pc;
    logic [15:0] m_done;

    always #2.5 clk = ~clk;

    retire_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .head_ready(rdy), .head_squashed(sq), .head_executed(ex),
        .head_serial(sr), .head_load(ld), .head_fault(ft), .head_store(stq),
        .head_seq(seqv), .stores_pending(sp), .trap_ack(ack),
        .retire_strobe(ret), .completed(cmp), .commit_count(cnt),
        .done_valid(dv), .done_seq(dseq),
        .nonspec_req(nsr), .nonspec_seq(nss),
        .uncached_req(ucr), .uncached_seq(ucs),
        .trap_req(trp), .stall(stl),
        .pc(pc), .next_pc(npc), .next_npc(nnpc)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_slots();
        rdy = '0; sq = '0; ex = '0; sr = '0; ld = '0; ft = '0; stq = '0;
        seqv = '0; sp = 1'b0; ack = 1'b0;
    endtask

    // kind: 0 commit, 1 squashed, 2 serial, 3 load, 4 fault, 5 commit store, 6 unknown
    task automatic put(input int i, input int kind, input logic [15:0] s);
        rdy[i] = 1'b1;
        sq[i]  = (kind == 1);
        ex[i]  = (kind == 0 || kind == 4 || kind == 5 || kind == 1);
        sr[i]  = (kind == 2);
        ld[i]  = (kind == 3);
        ft[i]  = (kind == 4);
        stq[i] = (kind == 5);
        seqv[i*SEQ_W +: SEQ_W] = s;
    endtask

    // Expected values derived from the requirements, then compared one clock later.
    task automatic step();
        logic [W-1:0] e_ret = '0, e_cmp = '0;
        int e_cnt = 0;
        bit e_ns = 0, e_uc = 0, e_raise = 0, e_stall = 0, stop;
        logic [15:0] e_nss = '0, e_ucs = '0, e_done;
        logic [31:0] e_pc;
        bit e_trap;
        e_done = m_done;
        stop = m_trap;
        for (int i = 0; i < W; i++) begin
            logic [15:0] s;
            bit free;
            s = seqv[i*SEQ_W +: SEQ_W];
            free = (e_cnt == 0) && !sp;
            if (!stop) begin
                if (!rdy[i]) stop = 1;
                else if (sq[i]) e_ret[i] = 1;
                else if (!ex[i]) begin
                    stop = 1; e_stall = 1;
                    if (sr[i]) begin
                        if (free) begin e_ns = 1; e_nss = s; end
                    end else if (ld[i]) begin
                        e_uc = 1; e_ucs = s;
                    end
                end else if (ft[i]) begin
                    stop = 1; e_stall = 1; e_raise = free;
                end else begin
                    e_ret[i] = 1; e_cmp[i] = !stq[i]; e_cnt++; e_done = s;
                end
            end
        end
        e_trap = m_trap ? !ack : e_raise;
        e_pc = m_pc + 32'(4 * e_cnt);
        @(negedge clk);
        chk(ret == e_ret, "R1 R2 retire_strobe", ret, e_ret);
        chk(int'(cnt) == e_cnt, "R1 R2 commit_count", cnt, e_cnt);
        chk(cmp == e_cmp, "R9 completed", cmp, e_cmp);
        chk(dv == (e_cnt != 0), "R8 done_valid", dv, e_cnt != 0);
        chk(dseq == e_done, "R8 done_seq", dseq, e_done);
        chk(nsr == e_ns, "R3 nonspec_req", nsr, e_ns);
        if (e_ns) chk(nss == e_nss, "R3 nonspec_seq", nss, e_nss);
        chk(ucr == e_uc, "R4 uncached_req", ucr, e_uc);
        if (e_uc) chk(ucs == e_ucs, "R4 uncached_seq", ucs, e_ucs);
        chk(trp == e_trap, "R5 R6 trap_req", trp, e_trap);
        chk(stl == e_stall, "R10 stall", stl, e_stall);
        chk(pc == e_pc, "R7 pc", pc, e_pc);
        chk(nnpc == e_pc + 32'd8 && npc == e_pc + 32'd4, "R7 next_pc/next_npc", nnpc, e_pc + 32'd8);
        m_trap = e_trap; m_pc = e_pc; m_done = e_done;
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        clear_slots();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_trap = 0; m_pc = PC0; m_done = '0;
        // R11: reset values
        chk(ret == '0 && cnt == '0 && !nsr && !ucr && !trp && !stl && !dv, "R11 reset outputs", {ret, cnt}, 0);
        chk(pc == PC0 && npc == PC0 + 4 && nnpc == PC0 + 8 && dseq == '0, "R11 reset pc", pc, PC0);

        // R7 R8: full width of commits
        clear_slots(); for (int i = 0; i < W; i++) put(i, 0, 16'h100 + 16'(i)); step();
        // R1: empty slot 0 blocks all
        clear_slots(); put(1, 0, 16'h200); step();
        // R1: gap in slot 2 stops later slots
        clear_slots(); put(0, 0, 16'h210); put(1, 5, 16'h211); put(3, 0, 16'h213); step();
        // R2: squashed ahead of a commit, then a serial head that must wait (R3)
        clear_slots(); put(0, 1, 16'h300); put(1, 0, 16'h301); put(2, 2, 16'h302); step();
        // R3: squash only, then serial with no earlier commit -> request
        clear_slots(); put(0, 1, 16'h310); put(1, 2, 16'h311); step();
        // R3: serial at slot 0 with stores pending -> wait
        clear_slots(); put(0, 2, 16'h320); sp = 1; step();
        // R3: serial over load priority
        clear_slots(); put(0, 2, 16'h330); ld[0] = 1; step();
        // R4: load with stores pending still requests
        clear_slots(); put(0, 0, 16'h340); put(1, 3, 16'h341); sp = 1; step();
        // R10: unexecuted of no kind
        clear_slots(); put(0, 6, 16'h350); step();
        // R5: fault behind a commit waits
        clear_slots(); put(0, 0, 16'h360); put(1, 4, 16'h361); step();
        // R5: fault with stores pending waits
        clear_slots(); put(0, 4, 16'h370); sp = 1; step();
        // R6: stray acknowledge with no trap pending
        clear_slots(); put(0, 0, 16'h380); ack = 1; step();
        // R5: fault at slot 0 raises trap
        clear_slots(); put(0, 4, 16'h390); step();
        // R6: held trap blocks commits
        clear_slots(); for (int i = 0; i < W; i++) put(i, 0, 16'h3A0 + 16'(i)); step();
        ack = 1; step();
        ack = 0; step();

        // randomised traffic
        for (int n = 0; n < 400; n++) begin
            clear_slots();
            for (int i = 0; i < W; i++) begin
                int r;
                r = int'($urandom_range(99));
                if ($urandom_range(99) < 85) begin
                    if (r < 45) put(i, 0, 16'($urandom));
                    else if (r < 55) put(i, 5, 16'($urandom));
                    else if (r < 68) put(i, 1, 16'($urandom));
                    else if (r < 78) put(i, 2, 16'($urandom));
                    else if (r < 88) put(i, 3, 16'($urandom));
                    else if (r < 96) put(i, 4, 16'($urandom));
                    else put(i, 6, 16'($urandom));
                    if ($urandom_range(9) == 0) ld[i] = 1'b1;
                end
            end
            sp  = ($urandom_range(99) < 30);
            ack = ($urandom_range(99) < 40);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule